// File: doc/BRIEF.md
# CVSD Delta Modulation Encoder

This block turns a stream of signed linear samples into a one-bit-per-tick slope-delta code. On every data-clock enable it compares the present sample with a locally rebuilt copy of the signal and sends out one bit: 1 when the sample is at or above the copy, 0 when it is below. The copy is held in a principal integrator that moves up or down by the current step size and leaks slowly toward zero. A syllabic integrator sets that step size. It grows the step whenever the compand logic sees a run of identical bits, and lets it shrink geometrically otherwise.

The control pins choose a 3-bit or a 4-bit run length for companding and can force a perfect idle pattern on the line. An output enable lets several encoders share one serial line. When the low-power control is asserted, the block stops working, its state is cleared, and the line is pulled low.

Top module: `cvsd_enc`

## Requirements
- R1: After reset the integrator is zero, the step is at its minimum and the registered bit is 0; with operation enabled and data enable high, bit_out reads 0 and bit_oe reads 1.
- R2: On a tick with idle_n=1, the new bit is 1 when the signed sample is greater than or equal to the integrator value, else 0. It appears on bit_out after the clock edge that samples the tick.
- R3: On each tick the integrator becomes acc - floor(acc/2^LEAK_SH) plus the pre-tick step (bit 1) or minus it (bit 0), clamped to the signed SAMPLE_W range.
- R4: With alg_short=1 a run is detected when the new bit completes 3 or more identical consecutive bits.
- R5: With alg_short=0 a run needs 4 or more identical consecutive bits.
- R6: On a tick with a run, step becomes min(step+STEP_INC, STEP_MAX). Without a run it becomes max(step - floor(step/2^DECAY_SH), STEP_MIN). The step always stays within [STEP_MIN, STEP_MAX].
- R7: While idle_n=0 the ticks emit 0,1,0,1,... starting with 0, whatever the sample. The integrator and step follow the emitted bits.
- R8: With pwr_on=1, bit_oe equals data_en. Encoding goes on while the output is released.
- R9: With pwr_on=0, bit_out is 0, bit_oe is 1, ticks are ignored, and the state is cleared as at reset.
- R10: Cycles without a tick change neither the output bit nor the integrator or the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Data-clock enable, one bit per high cycle |
| sample | input | SAMPLE_W | Signed linear input sample |
| alg_short | input | 1 | 1: 3-bit run companding, 0: 4-bit |
| idle_n | input | 1 | Active-low force of the 0101 idle pattern |
| data_en | input | 1 | Drive enable for the serial output |
| pwr_on | input | 1 | 1: operate, 0: low-power, state cleared |
| bit_out | output | 1 | Serial coded bit |
| bit_oe | output | 1 | Output enable (0 means high impedance) |

## Verification
The hardest point to reach from the ports is the step ceiling, together with integrator saturation. The step only climbs through long runs, and the leak keeps pulling the integrator back. The stimulus holds the sample at the positive full-scale value for many ticks until both limits are pinned. It then swings to negative full scale, so the decay and the run detection under both run lengths show up in the bit stream. A reference model in the bench predicts each bit from the stated arithmetic, so a wrong clamp or a wrong run threshold changes the predicted bits within a few ticks.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int step_upd(input int st, input logic run, input int inc,
                                  input int mn, input int mx, input int sh);
    if (run) return clamp_int(st + inc, mn, mx);
    return clamp_int(st - (st >>> sh), mn, mx);
  endfunction

  function automatic int integ_upd(input int acc, input int leak, input logic up,
                                   input int st, input int lo, input int hi);
    return clamp_int(acc - leak + (up ? st : -st), lo, hi);
  endfunction

endpackage

// File: rtl/cvsd_compand.sv
module cvsd_compand #(
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic bit_in,
  input  logic alg_short,
  output logic run_det
);
  localparam int LW = $clog2(RUN_LONG + 1);

  logic [LW-1:0] len_q, len_nx;
  logic          last_q;
  logic [LW-1:0] need;

  assign need = alg_short ? LW'(RUN_SHORT) : LW'(RUN_LONG);

  always_comb begin
    if (len_q != '0 && bit_in == last_q)
      len_nx = (len_q == LW'(RUN_LONG)) ? len_q : len_q + 1'b1;
    else
      len_nx = LW'(1);
  end

  assign run_det = tick && (len_nx >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      last_q <= 1'b0;
    end else if (clr) begin
      len_q  <= '0;
      last_q <= 1'b0;
    end else if (tick) begin
      len_q  <= len_nx;
      last_q <= bit_in;
    end
  end
endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic
  import cvsd_pkg::*;
#(
  parameter int STEP_W   = 11,
  parameter int STEP_MIN = 8,
  parameter int STEP_MAX = 1024,
  parameter int STEP_INC = 32,
  parameter int DECAY_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              run_det,
  output logic [STEP_W-1:0] step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      step <= STEP_W'(STEP_MIN);
    else if (clr)
      step <= STEP_W'(STEP_MIN);
    else if (tick)
      step <= STEP_W'(step_upd(int'(step), run_det, STEP_INC, STEP_MIN, STEP_MAX, DECAY_SH));
  end
endmodule

// File: rtl/cvsd_principal.sv
module cvsd_principal
  import cvsd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int STEP_W   = 11,
  parameter int LEAK_SH  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       tick,
  input  logic                       up,
  input  logic [STEP_W-1:0]          step,
  output logic signed [SAMPLE_W-1:0] integ
);
  localparam int ACC_MAX = 2 ** (SAMPLE_W - 1) - 1;
  localparam int ACC_MIN = -(2 ** (SAMPLE_W - 1));

  int leak;

  generate
    if (LEAK_SH == 0) begin : g_noleak
      assign leak = 0;
    end else begin : g_leak
      assign leak = int'(integ) >>> LEAK_SH;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      integ <= '0;
    else if (clr)
      integ <= '0;
    else if (tick)
      integ <= SAMPLE_W'(integ_upd(int'(integ), leak, up, int'(step), ACC_MIN, ACC_MAX));
  end
endmodule

// File: rtl/cvsd_enc.sv
module cvsd_enc #(
  parameter int SAMPLE_W  = 12,
  parameter int STEP_MIN  = 8,
  parameter int STEP_MAX  = 1024,
  parameter int STEP_INC  = 32,
  parameter int DECAY_SH  = 4,
  parameter int LEAK_SH   = 6,
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic                       alg_short,
  input  logic                       idle_n,
  input  logic                       data_en,
  input  logic                       pwr_on,
  output logic                       bit_out,
  output logic                       bit_oe
);
  localparam int STEP_W = SAMPLE_W - 1;

  logic                       clr, tick_w, cmp_bit, bit_nx, bit_q, idle_ph_q;
  logic                       run_det;
  logic [STEP_W-1:0]          step_w;
  logic signed [SAMPLE_W-1:0] integ_w;

  assign clr     = !pwr_on;
  assign tick_w  = tick && pwr_on;
  assign cmp_bit = (sample >= integ_w);
  assign bit_nx  = idle_n ? cmp_bit : idle_ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= 1'b0;
      idle_ph_q <= 1'b0;
    end else if (clr) begin
      bit_q     <= 1'b0;
      idle_ph_q <= 1'b0;
    end else if (tick_w) begin
      bit_q     <= bit_nx;
      idle_ph_q <= idle_n ? 1'b0 : !idle_ph_q;
    end
  end

  cvsd_compand #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)) u_comp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick_w),
    .bit_in(bit_nx), .alg_short(alg_short), .run_det(run_det)
  );

  cvsd_syllabic #(.STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
                  .STEP_INC(STEP_INC), .DECAY_SH(DECAY_SH)) u_syl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick_w),
    .run_det(run_det), .step(step_w)
  );

  cvsd_principal #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W), .LEAK_SH(LEAK_SH)) u_pri (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick_w),
    .up(bit_nx), .step(step_w), .integ(integ_w)
  );

  assign bit_out = pwr_on && bit_q;
  assign bit_oe  = pwr_on ? data_en : 1'b1;
endmodule

// File: rtl/cvsd_enc_chk.sv
module cvsd_enc_chk #(
  parameter int SAMPLE_W = 12,
  parameter int STEP_W   = 11,
  parameter int STEP_MIN = 8,
  parameter int STEP_MAX = 1024
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       pwr_on,
  input logic                       data_en,
  input logic                       bit_out,
  input logic                       bit_oe,
  input logic                       bit_q,
  input logic                       run_det,
  input logic [STEP_W-1:0]          step_w,
  input logic signed [SAMPLE_W-1:0] integ_w
);
  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(step_w) >= STEP_MIN) && (int'(step_w) <= STEP_MAX));

  // R6
  step_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && run_det) |=> (step_w >= $past(step_w)));

  // R6
  step_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && tick && !run_det) |=> (step_w <= $past(step_w)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !tick) |=> ($stable(integ_w) && $stable(step_w) && $stable(bit_q)));

  // R9
  sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (integ_w == '0 && int'(step_w) == STEP_MIN && !bit_q));

  // R9
  sleep_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (!bit_out && bit_oe));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !data_en) |-> !bit_oe);
endmodule

bind cvsd_enc cvsd_enc_chk #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W),
                             .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_on(pwr_on), .data_en(data_en),
  .bit_out(bit_out), .bit_oe(bit_oe), .bit_q(bit_q), .run_det(run_det),
  .step_w(step_w), .integ_w(integ_w)
);

// File: tb/cvsd_enc_tb_top.sv
module cvsd_enc_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SW = 12;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic alg_short = 1'b1, idle_n = 1'b1, data_en = 1'b1, pwr_on = 1'b1;
  logic bit_out, bit_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { bit b; bit oe; bit chk_b; string tag; } exp_t;
  exp_t q[$];

  // reference state
  int m_integ = 0, m_step = 8, m_run = 0, m_ph = 0;
  bit m_last = 0;

  always #2.5 clk = ~clk;

  cvsd_enc dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample),
    .alg_short(alg_short), .idle_n(idle_n), .data_en(data_en), .pwr_on(pwr_on),
    .bit_out(bit_out), .bit_oe(bit_oe));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_integ = 0; m_step = 8; m_run = 0; m_ph = 0; m_last = 0;
  endtask

  // reference arithmetic, written from the requirements
  function automatic bit model_tick(input int smp);
    bit b;
    int need, fl, ni;
    b = idle_n ? (smp >= m_integ) : bit'(m_ph);
    m_ph = idle_n ? 0 : 1 - m_ph;
    if (m_run > 0 && b == m_last) m_run = (m_run < 4) ? m_run + 1 : 4;
    else m_run = 1;
    m_last = b;
    need = alg_short ? 3 : 4;
    fl = m_integ / 64;
    if (m_integ < 0 && (m_integ % 64) != 0) fl = fl - 1;
    ni = m_integ - fl + (b ? m_step : -m_step);
    if (ni > 2047) ni = 2047;
    if (ni < -2048) ni = -2048;
    m_integ = ni;
    if (m_run >= need) begin
      m_step = m_step + 32;
      if (m_step > 1024) m_step = 1024;
    end else begin
      m_step = m_step - m_step / 16;
      if (m_step < 8) m_step = 8;
    end
    return b;
  endfunction

  // driver: one tick, expected result pushed into the scoreboard
  task automatic drive(input int smp, input string tag);
    exp_t e;
    @(negedge clk);
    sample = SW'(smp);
    tick = 1'b1;
    e.b = model_tick(smp);
    e.oe = data_en;
    e.chk_b = data_en;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    tick = 1'b0;
  endtask

  // monitor
  always @(posedge clk) begin
    if (tick && pwr_on && rst_n) begin
      #1;
      if (q.size() == 0) check("scoreboard underflow", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        if (e.chk_b) check({e.tag, " bit"}, int'(bit_out), int'(e.b));
        check({e.tag, " oe"}, int'(bit_oe), int'(e.oe));
      end
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out in reset", int'(bit_out), 0);
    check("R1 oe in reset", int'(bit_oe), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after reset", int'(bit_out), 0);

    // R2 zero sample vs zero integrator gives 1
    drive(0, "R2 equal");
    drive(-5, "R2 below");
    drive(300, "R2 above");

    // R4 short runs: ramp then full-scale to pin R3/R6 limits
    alg_short = 1'b1;
    for (int i = 0; i < 40; i++) drive(i * 40 - 800, "R4 ramp");
    for (int i = 0; i < 60; i++) drive(2047, "R3 R6 top sat");
    for (int i = 0; i < 60; i++) drive(-2048, "R3 R6 bottom sat");
    for (int i = 0; i < 50; i++) drive((i % 10 < 5) ? 900 : -900, "R4 square");

    // R5 long runs
    alg_short = 1'b0;
    for (int i = 0; i < 50; i++) drive((i % 10 < 5) ? 900 : -900, "R5 square");
    for (int i = 0; i < 40; i++) drive((i % 7) * 150 - 400, "R5 saw");

    // R10 gaps without tick
    drive(1500, "R10 before gap");
    begin
      int held;
      held = int'(bit_out);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        sample = (i % 2) ? 12'sd2000 : -12'sd2000;
        check("R10 held across gap", int'(bit_out), held);
      end
    end
    drive(-1500, "R10 after gap");

    // R7 forced idle ignores sample
    idle_n = 1'b0;
    for (int i = 0; i < 12; i++) drive((i % 3 == 0) ? 2047 : -2048, "R7 idle");
    idle_n = 1'b1;
    for (int i = 0; i < 8; i++) drive(100, "R7 resume");

    // R8 released output, encoding continues
    data_en = 1'b0;
    for (int i = 0; i < 8; i++) drive(i * 200 - 700, "R8 released");
    @(negedge clk);
    check("R8 oe low static", int'(bit_oe), 0);
    data_en = 1'b1;
    for (int i = 0; i < 6; i++) drive(-300, "R8 driven again");

    // R9 powersave
    @(negedge clk);
    pwr_on = 1'b0;
    @(negedge clk);
    check("R9 out forced low", int'(bit_out), 0);
    check("R9 oe driven", int'(bit_oe), 1);
    data_en = 1'b0;
    @(negedge clk);
    check("R9 oe ignores data_en", int'(bit_oe), 1);
    tick = 1'b1; sample = 12'sd2000;
    @(negedge clk);
    tick = 1'b0;
    check("R9 tick ignored", int'(bit_out), 0);
    data_en = 1'b1;
    pwr_on = 1'b1;
    model_clear();
    drive(0, "R9 cleared integ");
    drive(-1, "R9 cleared step");
    for (int i = 0; i < 10; i++) drive(500, "R9 restart");

    repeat (4) @(negedge clk);
    check("scoreboard drained", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule